// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog run entirely from one 8-bit control register. The register holds a 5-bit multiplier, a 2-bit resolution code and an action-select bit. The timeout is the multiplier times four to the power of the resolution code, counted in periods of a 1/16-second tick that arrives from outside as a one-cycle strobe. Software keeps the system alive either by writing the control register, which loads a new timeout, or simply by reading it, which restarts the count from the stored value.

When the count runs out, the block sets a sticky expiry flag in a read-only flags register and takes one of two actions. In reset mode it pulses a reset-request output, clears the control register (so the watchdog disarms) and clears the century bit in a companion day/century register. In interrupt mode it pulses an interrupt output and leaves the control register as it was. In both modes the count stops after expiry until software restarts it.

Register access is one byte wide. Address 0 is the control register, address 1 is the flags register (expiry flag in bit 7, other bits read 0), address 2 is the day/century register (century bit in bit 6, other bits read 0), and address 3 reads 0. Control bit 7 selects the action (1 = reset), bits 6:2 are the multiplier and bits 1:0 are the resolution code. Read data is combinational from the address.

Top module: `interval_watchdog`

## Requirements
- R1: After a restart with a non-zero multiplier M and resolution code S, expiry occurs on the clock edge that samples the (M * 4^S)-th tick, and not before it.
- R2: Writing 0x00 to the control register disarms the watchdog: no tick produces a pulse, and the expiry flag stays clear.
- R3: Any write to the control register clears the expiry flag (bit 7 at address 1) and restarts the count with the written value.
- R4: A read of the control register restarts the count with the stored value, without changing that value.
- R5: Expiry sets the expiry flag, which `flag_o` mirrors and which reads back as 0x80 at address 1.
- R6: On expiry with control bit 7 set, `rst_req` is high for exactly one cycle, the control register reads 0x00 afterwards and the century bit is cleared.
- R7: On expiry with control bit 7 clear, `irq` is high for exactly one cycle, `rst_req` stays low and the control register keeps its value.
- R8: Writes to address 1 have no effect on the expiry flag.
- R9: A non-zero control value whose multiplier field is zero expires on the very next tick.
- R10: Synchronous reset clears the control register, the flags, the century bit and both pulse outputs, and stops the count.
- R11: After expiry no further pulse occurs, whatever the ticks, until the count is restarted.
- R12: Writing address 2 stores data bit 6 as the century bit, shown on `century_o` and read back at bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per 1/16 second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| flag_o | output | 1 | Sticky expiry flag |
| century_o | output | 1 | Century bit |

## Verification
The bench aims at the off-by-one edge of the count: a design that expired one tick early or late would pulse on the wrong step of a directed run whose length is known. Zero-multiplier values with a non-zero resolution code are driven to catch a design that treated them as disabled or let the counter wrap to a huge timeout. Reads of the control register between ticks catch a design that ignored read-restart and expired on the original schedule, and writes to the flags register catch a flag that could be cleared from the bus. Random mixes of access and ticks in both action modes, compared each cycle with a bench model, catch a design that re-fired after expiry or failed to clear the control value and century bit in reset mode.

// File: rtl/iw_pkg.sv
package iw_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    localparam int SHIFT_MAX = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W     = MULT_W + SHIFT_MAX;
    localparam int FLAG_BIT  = 7;
    localparam int CENT_BIT  = 6;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_FLAGS = 2'd1,
        REG_CENT  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              hard;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_ctrl_t;

    // Timeout length in ticks: multiplier scaled by four to the resolution code.
    function automatic logic [CNT_W-1:0] span_of(wd_ctrl_t c);
        return CNT_W'(c.mult) << (2 * c.res);
    endfunction

endpackage

// File: rtl/iw_count.sv
module iw_count
    import iw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     restart,
    input  wd_ctrl_t load,
    output logic     expire
);

    logic             armed_q;
    logic [CNT_W-1:0] left_q;
    logic             last_tick;

    // A zero-length span is treated like a span of one.
    assign last_tick = (left_q <= CNT_W'(1));
    assign expire    = armed_q && tick && !restart && last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else if (restart) begin
            armed_q <= (load != '0);
            left_q  <= span_of(load);
        end else if (armed_q && tick) begin
            if (last_tick) begin
                armed_q <= 1'b0;
            end else begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/iw_regs.sv
module iw_regs
    import iw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic              restart,
    output wd_ctrl_t          load,
    output logic [DATA_W-1:0] rdata,
    output logic              flag,
    output logic              century,
    output logic              fire_rst,
    output logic              fire_irq
);

    wd_ctrl_t ctrl_q;
    logic     ctrl_wr;
    logic     ctrl_rd;
    logic     cent_wr;

    assign ctrl_wr = wr_en && (addr == REG_CTRL);
    assign ctrl_rd = rd_en && !wr_en && (addr == REG_CTRL);
    assign cent_wr = wr_en && (addr == REG_CENT);
    assign restart = ctrl_wr || ctrl_rd;
    assign load    = ctrl_wr ? wd_ctrl_t'(wdata) : ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            flag     <= 1'b0;
            century  <= 1'b0;
            fire_rst <= 1'b0;
            fire_irq <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= wd_ctrl_t'(wdata);
                flag   <= 1'b0;
            end
            if (cent_wr) begin
                century <= wdata[CENT_BIT];
            end
            if (expire) begin
                flag <= 1'b1;
                if (ctrl_q.hard) begin
                    ctrl_q  <= '0;
                    century <= 1'b0;
                end
            end
            fire_rst <= expire && ctrl_q.hard;
            fire_irq <= expire && !ctrl_q.hard;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(addr))
            REG_CTRL:  rdata = ctrl_q;
            REG_FLAGS: rdata[FLAG_BIT] = flag;
            REG_CENT:  rdata[CENT_BIT] = century;
            REG_SPARE: rdata = '0;
        endcase
    end

endmodule

// File: rtl/interval_watchdog.sv
module interval_watchdog
    import iw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req,
    output logic              irq,
    output logic              flag_o,
    output logic              century_o
);

    logic     restart;
    logic     expire;
    wd_ctrl_t load;

    iw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .expire   (expire),
        .restart  (restart),
        .load     (load),
        .rdata    (rdata),
        .flag     (flag_o),
        .century  (century_o),
        .fire_rst (rst_req),
        .fire_irq (irq)
    );

    iw_count u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .load    (load),
        .expire  (expire)
    );

endmodule

// File: rtl/iw_checker.sv
module iw_checker
    import iw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rst_req,
    input logic              irq,
    input logic              flag_o,
    input logic              century_o
);

    p_one_action_r6: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && irq));

    p_rst_single_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (rst_req || irq) |-> flag_o);

    p_flag_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> (rst_req || irq));

    p_century_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !century_o);

    // Only a control write may drop the flag; a flags-register write never does (R8).
    p_flag_fall_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag_o) && !$past(rst)) |-> $past(wr_en && (addr == REG_CTRL)));

    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!rst_req && !irq && !flag_o && !century_o));

endmodule

bind interval_watchdog iw_checker u_iw_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .rst_req   (rst_req),
    .irq       (irq),
    .flag_o    (flag_o),
    .century_o (century_o)
);

// File: tb/test_interval_watchdog.sv
module test_interval_watchdog;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rst_req, irq, flag_o, century_o;

    int checks = 0;
    int errors = 0;
    int pulses;

    // bench model
    logic [7:0] m_ctrl;
    logic       m_flag, m_cent, m_armed;
    int         m_ticks, m_len;
    logic       e_rst, e_irq;
    logic [7:0] obs_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_watchdog i_interval_watchdog (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req),
        .irq(irq), .flag_o(flag_o), .century_o(century_o)
    );

    function automatic int tout(logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return {m_flag, 7'b0};
            2'd2:    return {1'b0, m_cent, 6'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // One clock step: drive at negedge, check read data, update model, check outputs.
    task automatic step(logic tk, logic wr, logic rd, logic [1:0] a, logic [7:0] d);
        logic restart;
        tick = tk; wr_en = wr; rd_en = rd && !wr; addr = a; wdata = d;
        #1;
        obs_rdata = rdata;
        if (rd && !wr) chk("R4 R12 read data", rdata, exp_read(a));
        e_rst = 1'b0; e_irq = 1'b0;
        restart = (wr || rd) && (a == 2'd0);
        if (wr && a == 2'd2) m_cent = d[6];
        if (restart) begin
            if (wr) begin m_ctrl = d; m_flag = 1'b0; end
            m_armed = (m_ctrl != 8'h00);
            m_ticks = 0;
            m_len   = tout(m_ctrl);
        end else if (tk && m_armed) begin
            m_ticks++;
            if (m_ticks >= ((m_len == 0) ? 1 : m_len)) begin
                m_armed = 1'b0;
                m_flag  = 1'b1;
                if (m_ctrl[7]) begin
                    e_rst = 1'b1; m_ctrl = 8'h00; m_cent = 1'b0;
                end else begin
                    e_irq = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R6 rst_req", {7'b0, rst_req}, {7'b0, e_rst});
        chk("R7 irq", {7'b0, irq}, {7'b0, e_irq});
        chk("R5 flag_o", {7'b0, flag_o}, {7'b0, m_flag});
        chk("R12 century_o", {7'b0, century_o}, {7'b0, m_cent});
        if (rst_req || irq) pulses++;
        tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        step(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic rd_reg(logic [1:0] a);
        step(1'b0, 1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = 8'h00; m_flag = 1'b0; m_cent = 1'b0; m_armed = 1'b0;
        m_ticks = 0; m_len = 0; pulses = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 rst_req", {7'b0, rst_req}, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);
        chk("R10 flag_o", {7'b0, flag_o}, 8'h00);
        chk("R10 century_o", {7'b0, century_o}, 8'h00);
        rd_reg(2'd0); chk("R10 control", obs_rdata, 8'h00);
        pulses = 0; ticks(10); chk("R10 counter stopped", 8'(pulses), 8'h00);

        // R1: mult 3, res 1 -> 12 ticks, interrupt mode
        wr_reg(2'd0, 8'h0D);
        pulses = 0; ticks(11); chk("R1 early", 8'(pulses), 8'h00);
        ticks(1); chk("R1 expiry", {7'b0, irq}, 8'h01);
        rd_reg(2'd1); chk("R5 flag read", obs_rdata, 8'h80);
        rd_reg(2'd2); rd_reg(2'd3); chk("R7 spare", obs_rdata, 8'h00);

        // R11: no re-fire without restart
        pulses = 0; ticks(60); chk("R11 one-shot", 8'(pulses), 8'h00);

        // R8: flags ignore writes
        wr_reg(2'd1, 8'h00); rd_reg(2'd1); chk("R8 flags write", obs_rdata, 8'h80);
        wr_reg(2'd1, 8'hFF); chk("R8 flag_o", {7'b0, flag_o}, 8'h01);

        // R3: control write clears flag and restarts with new value (2 ticks)
        wr_reg(2'd0, 8'h08);
        rd_reg(2'd1); chk("R3 flag cleared", obs_rdata, 8'h00);
        pulses = 0; ticks(1); chk("R3 early", 8'(pulses), 8'h00);
        ticks(1); chk("R3 new value", {7'b0, irq}, 8'h01);

        // R4: read restarts with stored value (4 ticks)
        wr_reg(2'd0, 8'h10);
        pulses = 0; ticks(3); rd_reg(2'd0);
        chk("R4 value kept", obs_rdata, 8'h10);
        ticks(3); chk("R4 restarted", 8'(pulses), 8'h00);
        ticks(1); chk("R4 expiry", {7'b0, irq}, 8'h01);
        rd_reg(2'd0); chk("R7 control kept", obs_rdata, 8'h10);

        // R9: zero multiplier, non-zero resolution
        wr_reg(2'd0, 8'h02); ticks(1); chk("R9 next tick", {7'b0, irq}, 8'h01);

        // R2: disabled
        wr_reg(2'd0, 8'h00);
        pulses = 0; ticks(200);
        chk("R2 no pulse", 8'(pulses), 8'h00);
        chk("R2 flag clear", {7'b0, flag_o}, 8'h00);

        // R12 / R6: century bit, then reset-mode expiry (1 tick)
        wr_reg(2'd2, 8'h40); chk("R12 century set", {7'b0, century_o}, 8'h01);
        rd_reg(2'd2); chk("R12 century read", obs_rdata, 8'h40);
        wr_reg(2'd0, 8'h84); ticks(1);
        chk("R6 reset request", {7'b0, rst_req}, 8'h01);
        chk("R6 no irq", {7'b0, irq}, 8'h00);
        chk("R6 century cleared", {7'b0, century_o}, 8'h00);
        rd_reg(2'd0); chk("R6 control cleared", obs_rdata, 8'h00);

        // random mix against the model
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(99));
            logic tk = ($urandom_range(1) == 1);
            logic [7:0] v = 8'($urandom);
            if ($urandom_range(3) != 0) v[1] = 1'b0;
            if (r < 45)      step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
            else if (r < 52) step(tk, 1'b1, 1'b0, 2'd0, v);
            else if (r < 62) step(tk, 1'b0, 1'b1, 2'd0, 8'h00);
            else if (r < 67) step(tk, 1'b1, 1'b0, 2'd1, v);
            else if (r < 72) step(tk, 1'b1, 1'b0, 2'd2, v);
            else if (r < 85) step(tk, 1'b0, 1'b1, 2'($urandom_range(1, 3)), 8'h00);
            else             step(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        end
        summary();
    end

endmodule